// File: doc/BRIEF.md
# Double-Precision Funnel Shifter

This unit performs 16-bit double-width shifts. A destination word and a source word are joined into one wide value and shifted by a variable count. For a left shift, the destination sits in the upper half and the upper half of the shifted value is returned. For a right shift, the destination sits in the lower half and the lower half is returned. When the count exceeds the word width, the source word is inserted a second time. The operation then behaves as a shift of a three-word chain: destination, source, source.

The shift count comes from either an immediate field or a count register, selected by an input. Only the low five bits of the count are used. A masked count of zero changes nothing: no write is issued, and the result and every flag keep their earlier values. Results and flags are registered one cycle after the valid strobe, along with a done pulse.

The unit holds its own copy of the carry, parity, zero, sign and overflow flags. It also emits a per-flag update mask, so that an external flag register can merge only the bits that changed.

Top module: `dfs_funnel_shifter`

## Requirements
- R1: The effective count is taken from `imm_count` when `use_imm` is 1 and from `reg_count` otherwise. Only its low 5 bits are used; higher bits and the unselected source have no effect.
- R2: A masked count of zero gives `wr_en` = 0 and `flag_upd` = 0. `result` and all five flag outputs keep their previous values.
- R3: Left shift (`dir_right` = 0) with a count of 1..16 returns the upper 16 bits of {dest, src} shifted left by the count.
- R4: Left shift with a count of 17..31 returns bits 47..32 of {dest, src, src} shifted left by the count. The source word re-enters the low end of the result.
- R5: Right shift (`dir_right` = 1) returns bits 15..0 of {src, src, dest} shifted right by the count. For counts up to 16 this equals {src, dest} shifted right.
- R6: Carry is the last bit shifted out. For a left shift it is bit (32 − count) of {dest, src}. For a right shift it is bit (count − 1) of {src, dest}.
- R7: Overflow is updated only when the count is 1. It is then set when result bit 15 differs from dest bit 15.
- R8: On any nonzero count, zero = (result == 0), sign = result bit 15, and parity = 1 when the low result byte holds an even number of ones.
- R9: `flag_upd` bit 0 is carry, bit 1 parity, bit 2 zero, bit 3 sign and bit 4 overflow. A flag output whose update bit is 0 keeps its previous value.
- R10: Every accepted strobe produces `done` exactly one cycle later. A cycle without a strobe gives `done` = 0, `wr_en` = 0, `flag_upd` = 0, and unchanged result and flags.
- R11: During reset, `done`, `wr_en`, `flag_upd`, `result` and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| dir_right | input | 1 | 0 = left double shift, 1 = right double shift |
| use_imm | input | 1 | 1 = count from `imm_count`, 0 = from `reg_count` |
| imm_count | input | 8 | Immediate count field |
| reg_count | input | 8 | Count register value |
| dest_in | input | 16 | Destination operand |
| src_in | input | 16 | Source operand that is shifted in |
| done | output | 1 | One-cycle pulse after each strobe |
| wr_en | output | 1 | Result must be written back |
| result | output | 16 | Shifted word (held when no write) |
| cf_o | output | 1 | Carry flag |
| pf_o | output | 1 | Parity flag |
| zf_o | output | 1 | Zero flag |
| sf_o | output | 1 | Sign flag |
| of_o | output | 1 | Overflow flag |
| flag_upd | output | 5 | Per-flag update mask |

## Verification
The hardest condition to reach from the ports is a flag that must survive an operation. Overflow must hold through every count other than 1, and all flags must hold through a zero count. Those held values are only meaningful if an earlier operation left them set to something distinctive. The bench therefore sweeps every count from 0 to 31 in both directions and from both count sources, over several operand pairs in a fixed sequence. Each zero-count and multi-bit operation thus follows operations that left a range of flag states behind. The bench checks held flags against its own running flag model. It also places nonzero bits above the low five in the selected count, and a different value in the unselected source, so that masking and source selection are exercised on every operation.

// File: rtl/dfs_pkg.sv
package dfs_pkg;

    // Flag positions inside the update mask and the flag vector
    localparam int FLG_CF    = 0;
    localparam int FLG_PF    = 1;
    localparam int FLG_ZF    = 2;
    localparam int FLG_SF    = 3;
    localparam int FLG_OF    = 4;
    localparam int NUM_FLAGS = 5;

    typedef enum logic {
        SHIFT_LEFT  = 1'b0,
        SHIFT_RIGHT = 1'b1
    } shift_dir_e;

    // Even parity over one byte: 1 when the number of ones is even
    function automatic logic byte_even_parity(input logic [7:0] b);
        return ~(^b);
    endfunction

endpackage

// File: rtl/dfs_count_sel.sv
module dfs_count_sel #(
    parameter int CNT_IN_W = 8,
    parameter int CNT_W    = 5
) (
    input  logic                use_imm,
    input  logic [CNT_IN_W-1:0] imm_count,
    input  logic [CNT_IN_W-1:0] reg_count,
    output logic [CNT_W-1:0]    cnt,
    output logic                cnt_nz,
    output logic                cnt_one
);

    localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

    logic [CNT_IN_W-1:0] raw_cnt;
    logic                unused_hi;

    always_comb begin
        raw_cnt = use_imm ? imm_count : reg_count;
        cnt     = raw_cnt[CNT_W-1:0];
        cnt_nz  = |cnt;
        cnt_one = (cnt == ONE_C);
    end

    assign unused_hi = ^raw_cnt[CNT_IN_W-1:CNT_W];

endmodule

// File: rtl/dfs_funnel_core.sv
module dfs_funnel_core
    import dfs_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = $clog2(2 * DATA_W)
) (
    input  logic              dir_right,
    input  logic [DATA_W-1:0] dest,
    input  logic [DATA_W-1:0] src,
    input  logic [CNT_W-1:0]  cnt,
    output logic [DATA_W-1:0] res,
    output logic              carry
);

    localparam int CAT_W = 2 * DATA_W;
    localparam logic [CNT_W-1:0] HALF_C = CNT_W'(DATA_W);
    localparam logic [CNT_W:0]   FULL_C = (CNT_W + 1)'(CAT_W);

    logic [CAT_W-1:0] cat;
    logic [CAT_W-1:0] main_sh;
    logic [CAT_W-1:0] wrap_sh;
    logic [CAT_W-1:0] merged;
    logic [CAT_W:0]   ext;
    logic             wrap_en;
    logic [CNT_W:0]   wrap_amt;

    always_comb begin
        wrap_en = (cnt > HALF_C);
        if (shift_dir_e'(dir_right) == SHIFT_LEFT) begin
            cat      = {dest, src};
            main_sh  = cat << cnt;
            wrap_amt = {1'b0, cnt} - {1'b0, HALF_C};
            wrap_sh  = {{DATA_W{1'b0}}, src} << wrap_amt;
            ext      = {1'b0, cat} << cnt;
            carry    = ext[CAT_W];
        end else begin
            cat      = {src, dest};
            main_sh  = cat >> cnt;
            wrap_amt = FULL_C - {1'b0, cnt};
            wrap_sh  = {{DATA_W{1'b0}}, src} << wrap_amt;
            ext      = {cat, 1'b0} >> cnt;
            carry    = ext[0];
        end
        merged = main_sh | (wrap_en ? wrap_sh : '0);
        if (shift_dir_e'(dir_right) == SHIFT_LEFT) begin
            res = merged[CAT_W-1:DATA_W];
        end else begin
            res = merged[DATA_W-1:0];
        end
    end

endmodule

// File: rtl/dfs_flag_gen.sv
module dfs_flag_gen
    import dfs_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                 dest_msb,
    input  logic [DATA_W-1:0]    res,
    input  logic                 carry,
    input  logic                 cnt_nz,
    input  logic                 cnt_one,
    output logic [NUM_FLAGS-1:0] flg,
    output logic [NUM_FLAGS-1:0] upd
);

    always_comb begin
        flg         = '0;
        flg[FLG_CF] = carry;
        flg[FLG_PF] = byte_even_parity(res[7:0]);
        flg[FLG_ZF] = (res == '0);
        flg[FLG_SF] = res[DATA_W-1];
        flg[FLG_OF] = res[DATA_W-1] ^ dest_msb;

        upd         = '0;
        upd[FLG_CF] = cnt_nz;
        upd[FLG_PF] = cnt_nz;
        upd[FLG_ZF] = cnt_nz;
        upd[FLG_SF] = cnt_nz;
        upd[FLG_OF] = cnt_nz & cnt_one;
    end

endmodule

// File: rtl/dfs_funnel_shifter.sv
module dfs_funnel_shifter
    import dfs_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int CNT_IN_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 dir_right,
    input  logic                 use_imm,
    input  logic [CNT_IN_W-1:0]  imm_count,
    input  logic [CNT_IN_W-1:0]  reg_count,
    input  logic [DATA_W-1:0]    dest_in,
    input  logic [DATA_W-1:0]    src_in,
    output logic                 done,
    output logic                 wr_en,
    output logic [DATA_W-1:0]    result,
    output logic                 cf_o,
    output logic                 pf_o,
    output logic                 zf_o,
    output logic                 sf_o,
    output logic                 of_o,
    output logic [NUM_FLAGS-1:0] flag_upd
);

    localparam int CNT_W = $clog2(2 * DATA_W);

    typedef struct packed {
        logic                 done;
        logic                 wr;
        logic [DATA_W-1:0]    res;
        logic [NUM_FLAGS-1:0] flg;
        logic [NUM_FLAGS-1:0] upd;
    } unit_state_t;

    unit_state_t state_d, state_q;

    logic [CNT_W-1:0]     cnt;
    logic                 cnt_nz;
    logic                 cnt_one;
    logic [DATA_W-1:0]    core_res;
    logic                 core_carry;
    logic [NUM_FLAGS-1:0] new_flg;
    logic [NUM_FLAGS-1:0] new_upd;
    logic [NUM_FLAGS-1:0] merged_flg;

    dfs_count_sel #(
        .CNT_IN_W (CNT_IN_W),
        .CNT_W    (CNT_W)
    ) u_count (
        .use_imm   (use_imm),
        .imm_count (imm_count),
        .reg_count (reg_count),
        .cnt       (cnt),
        .cnt_nz    (cnt_nz),
        .cnt_one   (cnt_one)
    );

    dfs_funnel_core #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_core (
        .dir_right (dir_right),
        .dest      (dest_in),
        .src       (src_in),
        .cnt       (cnt),
        .res       (core_res),
        .carry     (core_carry)
    );

    dfs_flag_gen #(
        .DATA_W (DATA_W)
    ) u_flags (
        .dest_msb (dest_in[DATA_W-1]),
        .res      (core_res),
        .carry    (core_carry),
        .cnt_nz   (cnt_nz),
        .cnt_one  (cnt_one),
        .flg      (new_flg),
        .upd      (new_upd)
    );

    // Per-flag merge: take the new value only where its update bit is set
    for (genvar k = 0; k < NUM_FLAGS; k++) begin : g_merge
        assign merged_flg[k] = new_upd[k] ? new_flg[k] : state_q.flg[k];
    end

    always_comb begin
        state_d      = state_q;
        state_d.done = in_valid;
        state_d.wr   = in_valid & cnt_nz;
        state_d.upd  = in_valid ? new_upd : '0;
        if (in_valid) begin
            state_d.flg = merged_flg;
            if (cnt_nz) begin
                state_d.res = core_res;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign done     = state_q.done;
    assign wr_en    = state_q.wr;
    assign result   = state_q.res;
    assign cf_o     = state_q.flg[FLG_CF];
    assign pf_o     = state_q.flg[FLG_PF];
    assign zf_o     = state_q.flg[FLG_ZF];
    assign sf_o     = state_q.flg[FLG_SF];
    assign of_o     = state_q.flg[FLG_OF];
    assign flag_upd = state_q.upd;

endmodule

// File: rtl/dfs_funnel_shifter_chk.sv
module dfs_funnel_shifter_chk
    import dfs_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int CNT_IN_W = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic                 use_imm,
    input logic [CNT_IN_W-1:0]  imm_count,
    input logic [CNT_IN_W-1:0]  reg_count,
    input logic                 done,
    input logic                 wr_en,
    input logic [DATA_W-1:0]    result,
    input logic                 cf_o,
    input logic                 pf_o,
    input logic                 zf_o,
    input logic                 sf_o,
    input logic                 of_o,
    input logic [NUM_FLAGS-1:0] flag_upd
);

    localparam int CNT_W = $clog2(2 * DATA_W);

    logic [CNT_W-1:0] sel_cnt;
    logic             unused_chk;

    assign sel_cnt    = use_imm ? imm_count[CNT_W-1:0] : reg_count[CNT_W-1:0];
    assign unused_chk = ^{imm_count[CNT_IN_W-1:CNT_W], reg_count[CNT_IN_W-1:CNT_W]};

    p_done_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> done);

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!done && !wr_en && flag_upd == '0 && $stable(result)));

    p_zero_count_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sel_cnt == '0) |=> (!wr_en && flag_upd == '0 && $stable(result)));

    p_of_on_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sel_cnt == CNT_W'(1)) |=> flag_upd[FLG_OF]);

    p_of_off_many_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sel_cnt > CNT_W'(1)) |=> !flag_upd[FLG_OF]);

    p_cf_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_upd[FLG_CF] |-> $stable(cf_o));

    p_of_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_upd[FLG_OF] |-> $stable(of_o));

    p_sign_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flag_upd[FLG_SF] |-> (sf_o == result[DATA_W-1]));

    p_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flag_upd[FLG_ZF] |-> (zf_o == (result == '0)));

    p_parity_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flag_upd[FLG_PF] |-> (pf_o == ~(^result[7:0])));

    p_write_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (done && flag_upd[FLG_CF]));

endmodule

bind dfs_funnel_shifter dfs_funnel_shifter_chk #(
    .DATA_W   (DATA_W),
    .CNT_IN_W (CNT_IN_W)
) u_chk (.*);

// File: tb/tb_dfs_funnel_shifter.sv
`timescale 1ns/1ps
module tb_dfs_funnel_shifter;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic        dir_right;
    logic        use_imm;
    logic [7:0]  imm_count;
    logic [7:0]  reg_count;
    logic [15:0] dest_in;
    logic [15:0] src_in;
    logic        done;
    logic        wr_en;
    logic [15:0] result;
    logic        cf_o, pf_o, zf_o, sf_o, of_o;
    logic [4:0]  flag_upd;

    always #4 clk = ~clk;

    dfs_funnel_shifter dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dir_right(dir_right),
        .use_imm(use_imm), .imm_count(imm_count), .reg_count(reg_count),
        .dest_in(dest_in), .src_in(src_in), .done(done), .wr_en(wr_en),
        .result(result), .cf_o(cf_o), .pf_o(pf_o), .zf_o(zf_o), .sf_o(sf_o),
        .of_o(of_o), .flag_upd(flag_upd)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    // Running model of the registered outputs
    logic [15:0] m_res;
    logic        m_cf, m_pf, m_zf, m_sf, m_of;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_held(input string req);
        chk(req, "result", {16'h0, result}, {16'h0, m_res});
        chk(req, "flags", {27'h0, of_o, sf_o, zf_o, pf_o, cf_o},
            {27'h0, m_of, m_sf, m_zf, m_pf, m_cf});
    endtask

    task automatic run_op(input logic dr, input logic imm_sel, input logic [7:0] raw,
                          input logic [15:0] d, input logic [15:0] s);
        logic [4:0]  c;
        logic [47:0] w;
        logic [48:0] e;
        logic [15:0] r;
        logic        cy;
        string       rtag;
        c = raw[4:0];
        if (!dr) begin
            w  = {d, s, s} << c;
            r  = w[47:32];
            e  = {1'b0, d, s, s} << c;
            cy = e[48];
            rtag = (c > 5'd16) ? "R4" : "R3";
        end else begin
            w  = {s, s, d} >> c;
            r  = w[15:0];
            e  = {s, s, d, 1'b0} >> c;
            cy = e[0];
            rtag = "R5";
        end
        in_valid  = 1'b1;
        dir_right = dr;
        use_imm   = imm_sel;
        imm_count = imm_sel ? raw : ~raw;
        reg_count = imm_sel ? ~raw : raw;
        dest_in   = d;
        src_in    = s;
        if (c != 5'd0) begin
            m_res = r;
            m_cf  = cy;
            m_pf  = ($countones(r[7:0]) % 2) == 0;
            m_zf  = (r == 16'h0);
            m_sf  = r[15];
            if (c == 5'd1) m_of = r[15] ^ d[15];
        end
        @(negedge clk);
        in_valid = 1'b0;
        chk("R10", "done", {31'h0, done}, 32'h1);
        chk("R1", "wr_en", {31'h0, wr_en}, {31'h0, (c != 5'd0)});
        if (c == 5'd0) begin
            check_held("R2");
            chk("R2", "flag_upd", {27'h0, flag_upd}, 32'h0);
        end else begin
            chk(rtag, "result", {16'h0, result}, {16'h0, m_res});
            chk("R6", "carry", {31'h0, cf_o}, {31'h0, m_cf});
            chk("R7", "overflow", {31'h0, of_o}, {31'h0, m_of});
            chk("R8", "zero/sign/parity", {29'h0, zf_o, sf_o, pf_o},
                {29'h0, m_zf, m_sf, m_pf});
            chk("R9", "flag_upd", {27'h0, flag_upd},
                {27'h0, (c == 5'd1), 4'b1111});
        end
        @(negedge clk);
        chk("R10", "idle done", {30'h0, done, wr_en}, 32'h0);
        chk("R10", "idle flag_upd", {27'h0, flag_upd}, 32'h0);
        check_held("R10");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] pd [6];
        logic [15:0] ps [6];
        pd = '{16'h0000, 16'hFFFF, 16'h8001, 16'hA5C3, 16'h7FFF, 16'h0001};
        ps = '{16'h0000, 16'h0000, 16'h1234, 16'h5A3C, 16'hFFFF, 16'h8000};
        rst_n = 1'b0; in_valid = 1'b0; dir_right = 1'b0; use_imm = 1'b0;
        imm_count = 8'h0; reg_count = 8'h0; dest_in = 16'h0; src_in = 16'h0;
        m_res = 16'h0; m_cf = 0; m_pf = 0; m_zf = 0; m_sf = 0; m_of = 0;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11", "reset done/wr", {30'h0, done, wr_en}, 32'h0);
        chk("R11", "reset result", {16'h0, result}, 32'h0);
        chk("R11", "reset flags", {22'h0, flag_upd, of_o, sf_o, zf_o, pf_o, cf_o}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10", "no strobe", {31'h0, done}, 32'h0);
        for (int p = 0; p < 6; p++) begin
            for (int dr = 0; dr < 2; dr++) begin
                for (int im = 0; im < 2; im++) begin
                    for (int c = 0; c < 32; c++) begin
                        run_op(dr[0], im[0], {3'(c + p + im), 5'(c)}, pd[p], ps[p]);
                    end
                end
            end
        end
        // R2/R9: hold through a zero count and a count-2 op after distinctive flags
        run_op(1'b0, 1'b1, 8'h01, 16'h4000, 16'h0000);
        run_op(1'b1, 1'b0, 8'h60, 16'h1234, 16'hFFFF);
        run_op(1'b1, 1'b0, 8'h02, 16'h0003, 16'h0000);
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule